// File: doc/BRIEF.md
# Frame Clock Ratio Speed Detector

This block runs on the master clock of an audio converter that receives its frame clock from outside. It counts how many master clock cycles fall between successive rising edges of the incoming frame clock. The count is matched against a small set of nominal ratios, and the match picks the converter's speed mode (single, double or quad). It also decides whether the master clock must be halved so that the modulator always sees the same internal rate. Because of this, the speed mode needs no configuration pins.

A side input states whether the master clock belongs to the fast class. That input settles the two ratios that could mean either of two speed modes. A ratio of 64 master clock cycles per frame is only legal when the converter drives its own clocks. In this receiving role it is refused, like any count that matches no nominal ratio. A lock flag shows that the detected ratio has been steady over consecutive frames.

Top module: `lrck_speed_detect`

## Requirements
- R1: After a synchronous active-low reset, `speed_mode` is 2'b11 (no mode), `mclk_div2` is 0, and `locked` and `unsupported` are both 0.
- R2: The frame clock passes through a two-stage synchroniser. Each measurement is the number of `mclk` cycles from one rising edge of the frame clock to the next. The high time of the frame clock (40 to 60 percent of the period) has no effect on the result.
- R3: A count within plus or minus 2 cycles of a nominal ratio (64, 128, 256 or 512) is treated as that ratio. Any other count sets `unsupported` to 1, `speed_mode` to 2'b11 and `mclk_div2` to 0.
- R4: A ratio of 512 with `fast_mclk`=1 gives single speed (`speed_mode`=2'b00) with `mclk_div2`=1. With `fast_mclk`=0 the same ratio is unsupported.
- R5: A ratio of 256 gives single speed (2'b00, `mclk_div2`=0) when `fast_mclk`=0, and double speed (2'b01, `mclk_div2`=1) when `fast_mclk`=1.
- R6: A ratio of 128 gives double speed (2'b01, `mclk_div2`=0) when `fast_mclk`=0, and quad speed (2'b10, `mclk_div2`=1) when `fast_mclk`=1.
- R7: A ratio of 64 is always unsupported, whatever the value of `fast_mclk`.
- R8: `locked` is 1 only when the latest two measurements are both legal and map to the same nominal ratio (for example 256 then 257). It drops to 0 on a measurement with a different ratio or on an unsupported measurement.
- R9: If no rising frame clock edge arrives within 2047 `mclk` cycles of the last one, a measurement is forced. That measurement is unsupported, and `locked` drops.
- R10: The outputs change only when a measurement completes. Results appear no later than 4 `mclk` cycles after the frame clock rises, and they hold until the next measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck_async | input | 1 | Frame clock from outside, asynchronous to `mclk` |
| fast_mclk | input | 1 | 1 when the master clock is of the fast class |
| speed_mode | output | 2 | 00 single, 01 double, 10 quad, 11 none |
| mclk_div2 | output | 1 | 1 when the master clock must be halved internally |
| locked | output | 1 | Ratio steady over the last two measurements |
| unsupported | output | 1 | Latest measurement matched no legal ratio |

## Verification
The assertions take for granted that the output registers move only in the cycle after a completed measurement. They also assume that the class input is meaningful only at those moments. The stimulus drives the frame clock on the falling edge of `mclk`, so every period it applies is measured exactly. Each random frame has a high time between 40 and 60 percent of its period, and each period lies within four cycles of a nominal ratio. The class input changes only between runs of frames, and every run is long enough for the final two measurements to see the same period.

// File: rtl/speed_det_pkg.sv
// Shared types for the frame clock ratio speed detector.
package speed_det_pkg;

    // Speed mode code seen on the speed_mode port
    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_NONE   = 2'b11
    } speed_e;

    // Number of nominal ratios recognised (BASE, 2*BASE, 4*BASE, 8*BASE)
    localparam int NUM_RATIOS = 4;

endpackage

// File: rtl/lrck_edge_sync.sv
// Brings the asynchronous frame clock into the mclk domain and flags its
// rising edges.
// Assumes: SYNC_STAGES >= 2; frame clock high and low phases each last
// several mclk cycles.
module lrck_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic rst_n,
    input  logic lrck_async,
    output logic rise
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         prev_q;

    // Shift the raw level through the synchroniser and keep one delayed copy
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[MSB-1:0], lrck_async};
            prev_q <= sync_q[MSB];
        end
    end

    // Rising edge of the synchronised level
    always_comb rise = sync_q[MSB] & ~prev_q;

endmodule

// File: rtl/lrck_period_counter.sv
// Counts mclk cycles between rising frame clock edges. When a measurement
// is complete it issues a one-cycle meas_valid together with the period.
// If the count saturates, it forces a single measurement of CNT_MAX.
// Assumes: the first edge after reset only arms the counter.
module lrck_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             mclk,
    input  logic             rst_n,
    input  logic             rise,
    output logic             meas_valid,
    output logic [CNT_W-1:0] period
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    // Cycle counter with capture on edge and one-shot timeout
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            armed_q    <= 1'b0;
            meas_valid <= 1'b0;
            period     <= '0;
        end else begin
            meas_valid <= 1'b0;
            if (rise) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
                if (armed_q) begin
                    meas_valid <= 1'b1;
                    period     <= (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
                end
            end else if (cnt_q == CNT_PRE) begin
                cnt_q      <= CNT_MAX;
                meas_valid <= 1'b1;
                period     <= CNT_MAX;
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ratio_classifier.sv
// Matches a period count against the nominal ratios within +/-TOL cycles.
// It then maps the matched ratio and the clock class to a speed mode and a
// divider setting. Purely combinational.
// Assumes: BASE_RATIO << 3 plus TOL fits in CNT_W bits.
module ratio_classifier
    import speed_det_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int BASE_RATIO = 64,
    parameter int TOL        = 2
) (
    input  logic [CNT_W-1:0] period,
    input  logic             fast_mclk,
    output logic             legal,
    output logic [1:0]       ratio_idx,
    output speed_e           mode,
    output logic             div2
);
    logic [NUM_RATIOS-1:0] hit;

    // One window comparator per nominal ratio
    for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_win
        localparam int NOM = BASE_RATIO << k;
        localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
        localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
        always_comb hit[k] = (period >= LO) && (period <= HI);
    end

    // Encode the matching window and map it to mode and divider
    always_comb begin
        ratio_idx = 2'd0;
        for (int k = 0; k < NUM_RATIOS; k++) begin
            if (hit[k]) ratio_idx = 2'(k);
        end
        legal = 1'b0;
        mode  = SPD_NONE;
        if (hit != '0) begin
            case (ratio_idx)
                2'd1: begin legal = 1'b1; mode = fast_mclk ? SPD_QUAD   : SPD_DOUBLE; end
                2'd2: begin legal = 1'b1; mode = fast_mclk ? SPD_DOUBLE : SPD_SINGLE; end
                2'd3: begin legal = fast_mclk; mode = fast_mclk ? SPD_SINGLE : SPD_NONE; end
                default: begin legal = 1'b0; mode = SPD_NONE; end
            endcase
        end
        div2 = legal & fast_mclk;
    end

endmodule

// File: rtl/lrck_speed_detect.sv
// Top: measures mclk cycles per frame clock period and derives the speed
// mode, the internal divider setting, a lock flag and an unsupported flag.
// Assumes: fast_mclk is steady around the moment a measurement completes.
module lrck_speed_detect
    import speed_det_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_RATIO  = 64,
    parameter int TOL         = 2
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       lrck_async,
    input  logic       fast_mclk,
    output logic [1:0] speed_mode,
    output logic       mclk_div2,
    output logic       locked,
    output logic       unsupported
);
    localparam int MAX_RATIO = BASE_RATIO << (NUM_RATIOS - 1);
    localparam int CNT_W     = $clog2(MAX_RATIO) + 2;

    logic             rise;
    logic             meas_valid;
    logic [CNT_W-1:0] period;
    logic             cls_legal;
    logic [1:0]       cls_idx;
    speed_e           cls_mode;
    logic             cls_div2;

    speed_e           mode_q;
    logic             div2_q, locked_q, unsup_q;
    logic             prev_legal_q;
    logic [1:0]       prev_idx_q;

    lrck_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .mclk(mclk), .rst_n(rst_n), .lrck_async(lrck_async), .rise(rise)
    );

    lrck_period_counter #(.CNT_W(CNT_W)) cnt_i (
        .mclk(mclk), .rst_n(rst_n), .rise(rise),
        .meas_valid(meas_valid), .period(period)
    );

    ratio_classifier #(.CNT_W(CNT_W), .BASE_RATIO(BASE_RATIO), .TOL(TOL)) cls_i (
        .period(period), .fast_mclk(fast_mclk), .legal(cls_legal),
        .ratio_idx(cls_idx), .mode(cls_mode), .div2(cls_div2)
    );

    // Update the results and the lock history on each completed measurement
    always_ff @(posedge mclk) begin
        if (!rst_n) begin
            mode_q       <= SPD_NONE;
            div2_q       <= 1'b0;
            locked_q     <= 1'b0;
            unsup_q      <= 1'b0;
            prev_legal_q <= 1'b0;
            prev_idx_q   <= 2'd0;
        end else if (meas_valid) begin
            mode_q       <= cls_mode;
            div2_q       <= cls_div2;
            unsup_q      <= ~cls_legal;
            locked_q     <= cls_legal && prev_legal_q && (cls_idx == prev_idx_q);
            prev_legal_q <= cls_legal;
            prev_idx_q   <= cls_idx;
        end
    end

    assign speed_mode  = mode_q;
    assign mclk_div2   = div2_q;
    assign locked      = locked_q;
    assign unsupported = unsup_q;

endmodule

// File: rtl/speed_det_checker.sv
// Property checks for lrck_speed_detect, attached with bind.
// Assumes: meas_valid is the counter's completed-measurement strobe.
module speed_det_checker (
    input logic       mclk,
    input logic       rst_n,
    input logic [1:0] speed_mode,
    input logic       mclk_div2,
    input logic       locked,
    input logic       unsupported,
    input logic       meas_valid
);
    // R8: lock is never claimed on an unsupported measurement
    a_r8_lock_legal: assert property (@(posedge mclk) disable iff (!rst_n)
        locked |-> !unsupported);

    // R3: an unsupported result shows no mode and no division
    a_r3_unsup_outputs: assert property (@(posedge mclk) disable iff (!rst_n)
        unsupported |-> (speed_mode == 2'b11) && !mclk_div2);

    // R8: a locked result always carries a real speed mode
    a_r8_lock_mode: assert property (@(posedge mclk) disable iff (!rst_n)
        locked |-> speed_mode != 2'b11);

    // R10: outputs hold unless a measurement just completed
    a_r10_hold_mode: assert property (@(posedge mclk) disable iff (!rst_n)
        !meas_valid |=> $stable(speed_mode) && $stable(mclk_div2));

    // R10: flags hold unless a measurement just completed
    a_r10_hold_flags: assert property (@(posedge mclk) disable iff (!rst_n)
        !meas_valid |=> $stable(locked) && $stable(unsupported));

    // R4: the divider is only requested together with a speed mode
    a_r4_div_mode: assert property (@(posedge mclk) disable iff (!rst_n)
        mclk_div2 |-> speed_mode != 2'b11);

endmodule

bind lrck_speed_detect speed_det_checker chk_i (
    .mclk(mclk), .rst_n(rst_n), .speed_mode(speed_mode), .mclk_div2(mclk_div2),
    .locked(locked), .unsupported(unsupported), .meas_valid(meas_valid)
);

// File: tb/lrck_speed_detect_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random frames.
module lrck_speed_detect_tb_top;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck_async = 1'b0;
    logic       fast_mclk = 1'b0;
    logic [1:0] speed_mode;
    logic       mclk_div2, locked, unsupported;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 mclk = ~mclk;

    lrck_speed_detect dut_i (
        .mclk(mclk), .rst_n(rst_n), .lrck_async(lrck_async), .fast_mclk(fast_mclk),
        .speed_mode(speed_mode), .mclk_div2(mclk_div2), .locked(locked),
        .unsupported(unsupported)
    );

    // Expected mode/div/unsupported from the requirements
    function automatic void expect_for(input int p, input bit fast,
                                       output logic [1:0] m, output bit d, output bit u);
        int nom = 0;
        for (int k = 0; k < 4; k++) begin
            int n = 64 << k;
            if (p >= n - 2 && p <= n + 2) nom = n;
        end
        m = 2'b11; d = 1'b0; u = 1'b1;
        case (nom)
            128: begin m = fast ? 2'b10 : 2'b01; d = fast; u = 1'b0; end
            256: begin m = fast ? 2'b01 : 2'b00; d = fast; u = 1'b0; end
            512: if (fast) begin m = 2'b00; d = 1'b1; u = 1'b0; end
            default: ;
        endcase
    endfunction

    task automatic check(input string req, input logic [1:0] m, input bit d,
                         input bit lk, input bit u);
        n_checks++;
        if (speed_mode !== m || mclk_div2 !== d || locked !== lk || unsupported !== u) begin
            n_fail++;
            $display("FAIL %s: got mode=%b div=%b lock=%b unsup=%b, expected mode=%b div=%b lock=%b unsup=%b",
                     req, speed_mode, mclk_div2, locked, unsupported, m, d, lk, u);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge mclk);
    endtask

    task automatic lead_in();
        lrck_async = 1'b0;
        cycles(20);
    endtask

    task automatic frame(input int p, input int hi);
        lrck_async = 1'b1;
        cycles(hi);
        lrck_async = 1'b0;
        cycles(p - hi);
    endtask

    task automatic close_out();
        lrck_async = 1'b1;
        cycles(8);
    endtask

    // Run frames of period p, then check the result against the model
    task automatic run_and_check(input string req, input int p, input int hi, input bit fast);
        logic [1:0] m; bit d; bit u;
        fast_mclk = fast;
        lead_in();
        for (int i = 0; i < 3; i++) frame(p, hi);
        close_out();
        expect_for(p, fast, m, d, u);
        check(req, m, d, !u, u);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge mclk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd5341));
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        check("R1 reset state", 2'b11, 1'b0, 1'b0, 1'b0);

        run_and_check("R5 256 normal", 256, 128, 1'b0);
        run_and_check("R5 256 fast", 256, 128, 1'b1);
        run_and_check("R6 128 normal", 128, 64, 1'b0);
        run_and_check("R6 128 fast", 128, 64, 1'b1);
        run_and_check("R4 512 fast", 512, 256, 1'b1);
        run_and_check("R4 512 normal", 512, 256, 1'b0);
        run_and_check("R7 64 normal", 64, 32, 1'b0);
        run_and_check("R7 64 fast", 64, 32, 1'b1);
        run_and_check("R3 edge +2", 258, 128, 1'b0);
        run_and_check("R3 edge -2", 126, 64, 1'b1);
        run_and_check("R3 outside +3", 259, 128, 1'b0);
        run_and_check("R3 outside -3", 509, 256, 1'b1);
        run_and_check("R2 duty 40pct", 256, 102, 1'b1);
        run_and_check("R2 duty 60pct", 256, 154, 1'b1);

        // R8: a change of ratio on the last frame drops lock
        fast_mclk = 1'b0;
        lead_in();
        for (int i = 0; i < 3; i++) frame(256, 128);
        frame(128, 64);
        close_out();
        check("R8 ratio change drops lock", 2'b01, 1'b0, 1'b0, 1'b0);

        // R8: counts inside one window still lock
        lead_in();
        frame(256, 128); frame(255, 128); frame(257, 128);
        close_out();
        check("R8 lock within window", 2'b00, 1'b0, 1'b1, 1'b0);

        // R10: results hold across the following frame's high phase
        cycles(50);
        check("R10 hold between edges", 2'b00, 1'b0, 1'b1, 1'b0);

        // R9: frame clock stalls high; forced measurement is unsupported
        cycles(2100);
        check("R9 stalled clock", 2'b11, 1'b0, 1'b0, 1'b1);

        // Random periods near the nominal ratios, random duty and class
        for (int i = 0; i < 16; i++) begin
            int p   = (64 << $urandom_range(0, 3)) + $urandom_range(0, 8) - 4;
            int hi  = (p * $urandom_range(40, 60)) / 100;
            bit fst = 1'($urandom_range(0, 1));
            run_and_check("R3 random", p, hi, fst);
        end

        // R1: reset clears results again
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
        check("R1 reset after run", 2'b11, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule